// File: doc/BRIEF.md
# Programmable Decade Interval Timer

This block is a 16-bit interval timer driven from a fixed reference clock. A chain of decade dividers provides seven tick periods, each ten times longer than the one below it. The shortest period is `BASE_DIV` reference cycles, which is 10 us at 10 MHz with the default of 100. Each tick advances a count register, and the register is compared for equality with a programmable limit. A match sets a limit-match flag. A further match while that flag is still set raises a separate lost-tick flag instead. The count can optionally return to zero on a match.

Software reaches the block through four single-cycle strobes: control write, status read, data write and data read. A third interrupt source, the system flag, is set by an external pulse. A level interrupt request combines the system flag with the two timer flags.

The reads are registered. `rd_data_o` takes the selected word at the clock edge that ends the strobe cycle and holds it until the next read. The interrupt output is also registered, and it changes at the same edge as the flags that drive it.

Top module: `dec_itimer`

## Requirements
Bit numbering: word bit n has bit 0 as the most significant bit, so it is vector index 15-n.

- R1: A control write with word bit 3 (index 12) set loads the rate code from word bits 0-2 (index 15:13). With index 12 clear, the rate is left unchanged.
- R2: Rate code r from 1 to 7 gives one tick every `BASE_DIV*STEP_DIV^(r-1)` cycles. Loading a rate clears the divider, so the first tick comes a full period after the load edge. Code 0 stops the count while the divider keeps running.
- R3: Each tick increments the count modulo 2^`CNT_W`. A data read strobe makes `rd_data_o` equal to the count, zero-extended, after the next edge.
- R4: A match is the incremented count equal to the limit; only equality counts, so a limit at or below the count matches only after a wrap. Word bit 8 (index 7) set makes a match also clear the count.
- R5: A match while the limit-match flag is set raises the lost-tick flag and leaves the limit-match flag set.
- R6: A data write with word bit 9 (index 6) of the last control word at 0 loads the limit from the data. With that bit at 1, the write clears the count and ignores the data.
- R7: A control write with word bit 10 (index 5) clears all three flags, taking priority over the clear selector. Otherwise word bits 5-7 (index 10:8) clear one flag: 1 the limit-match flag, 2 the lost-tick flag, 3 the system flag. Codes 0 and 4-7 clear nothing.
- R8: A status read returns index 15 = 0, index 14 = 1, index 13:11 = rate, index 5 = limit-match, index 4 = lost-tick, index 2 = system flag, index 1 = write-target selector and index 0 = count-clear selector. All other bits read 0.
- R9: `io_rst_i`, or a control write with index 12 = 0 and index 15 = 1, clears the count, limit, rate, all flags and the three selectors. Afterwards the status reads 16'h4000.
- R10: `sys_set_i` sets the system flag. `irq_o` equals the system flag OR (enable AND (limit-match OR lost-tick)), where the enable is word bit 15 (index 0).
- R11: Within one cycle, a flag set beats a flag clear. A match tests the limit-match flag after that cycle's clear. A count-clearing data write beats a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rst_i | input | 1 | External I/O reset, same effect as master reset plus read data clear |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_word_i | input | 16 | Control word |
| sts_rd_i | input | 1 | Status read strobe |
| dat_wr_i | input | 1 | Data write strobe |
| wr_data_i | input | 16 | Data write value |
| dat_rd_i | input | 1 | Data (count) read strobe |
| sys_set_i | input | 1 | Sets the system interrupt flag |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- At most one read strobe is high in any cycle; if both are high, status wins.
- A data write acts on the write-target selector latched before that cycle.
- `BASE_DIV` and `STEP_DIV` are both at least 2.

The random stimulus drives one operation per cycle. It keeps rate codes low and limits small so that matches, wraps and lost ticks occur within the run. It issues master resets only on purpose, by clearing index 15 whenever index 12 is clear. Directed cases add the same-cycle collision of a system set with a clear-all.

// File: rtl/dit_pkg.sv
package dit_pkg;

  localparam int WORD_W    = 16;
  localparam int RATE_W    = 3;
  localparam int NUM_RATES = (1 << RATE_W) - 1;

  typedef enum logic [2:0] {
    CLR_NONE  = 3'd0,
    CLR_LIMIT = 3'd1,
    CLR_LOST  = 3'd2,
    CLR_SYS   = 3'd3
  } clr_code_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              load_rate;
    logic              mreset;
    clr_code_e         clr_code;
    logic              clr_all;
    logic              cnt_clr_en;
    logic              wr_to_cnt;
    logic              irq_en;
  } ctl_t;

  // Control word field extraction (index = 15 - word bit).
  function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.rate       = w[15:13];
    c.load_rate  = w[12];
    c.mreset     = w[15] & ~w[12];
    c.clr_code   = clr_code_e'(w[10:8]);
    c.clr_all    = w[5];
    c.cnt_clr_en = w[7];
    c.wr_to_cnt  = w[6];
    c.irq_en     = w[0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic [RATE_W-1:0] rate,
    input logic lim_f, input logic lost_f, input logic sys_f,
    input logic wr_to_cnt, input logic cnt_clr_en);
    logic [WORD_W-1:0] s;
    s        = '0;
    s[14]    = 1'b1;
    s[13:11] = rate;
    s[5]     = lim_f;
    s[4]     = lost_f;
    s[2]     = sys_f;
    s[1]     = wr_to_cnt;
    s[0]     = cnt_clr_en;
    return s;
  endfunction

endpackage

// File: rtl/dit_divider.sv
module dit_divider
  import dit_pkg::*;
#(
  parameter int BASE_DIV = 100,
  parameter int STEP_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  localparam int BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int STEP_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;

  logic [NUM_RATES-1:0] term;   // stage at its last state
  logic [NUM_RATES-1:0] carry;  // stage and all below at last state
  logic [BASE_W-1:0]    base_q;

  always_ff @(posedge clk) begin
    if (rst || restart)            base_q <= '0;
    else if (term[0])              base_q <= '0;
    else                           base_q <= base_q + 1'b1;
  end

  assign term[0]  = (base_q == BASE_W'(BASE_DIV - 1));
  assign carry[0] = term[0];

  for (genvar g = 1; g < NUM_RATES; g++) begin : g_stage
    logic [STEP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || restart)       q <= '0;
      else if (carry[g-1])      q <= term[g] ? '0 : q + 1'b1;
    end
    assign term[g]  = (q == STEP_W'(STEP_DIV - 1));
    assign carry[g] = &term[g:0];
  end

  always_comb begin
    tick_o = 1'b0;
    if (rate_i != '0 && !restart)
      tick_o = carry[rate_i - 3'd1];
  end

endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             wr_to_cnt_i,
  input  logic             cnt_clr_en_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign match_o = tick_i && (cnt_inc == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (tick_i)
      cnt_d = (match_o && cnt_clr_en_i) ? '0 : cnt_inc;
    if (wr_en_i) begin
      if (wr_to_cnt_i) cnt_d = '0;
      else             lim_d = wr_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dit_flags.sv
module dit_flags
  import dit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ctl_wr_i,
  input  logic      clr_all_i,
  input  clr_code_e clr_code_i,
  input  logic      match_i,
  input  logic      sys_set_i,
  output logic      lim_q,
  output logic      lost_q,
  output logic      sys_q,
  output logic      lim_d,
  output logic      lost_d,
  output logic      sys_d
);

  logic lim_k, lost_k, sys_k;

  // Clears first, then sets: a set in the same cycle survives.
  always_comb begin
    lim_k  = lim_q;
    lost_k = lost_q;
    sys_k  = sys_q;
    if (ctl_wr_i) begin
      if (clr_all_i) begin
        lim_k  = 1'b0;
        lost_k = 1'b0;
        sys_k  = 1'b0;
      end else begin
        unique case (clr_code_i)
          CLR_LIMIT: lim_k  = 1'b0;
          CLR_LOST:  lost_k = 1'b0;
          CLR_SYS:   sys_k  = 1'b0;
          default:   ;
        endcase
      end
    end
    if (rst) begin
      lim_d  = 1'b0;
      lost_d = 1'b0;
      sys_d  = 1'b0;
    end else begin
      lim_d  = lim_k | match_i;
      lost_d = lost_k | (match_i & lim_k);
      sys_d  = sys_k | sys_set_i;
    end
  end

  always_ff @(posedge clk) begin
    lim_q  <= lim_d;
    lost_q <= lost_d;
    sys_q  <= sys_d;
  end

endmodule

// File: rtl/dec_itimer.sv
module dec_itimer
  import dit_pkg::*;
#(
  parameter int BASE_DIV = 100,
  parameter int STEP_DIV = 10,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_rst_i,
  input  logic        ctl_wr_i,
  input  logic [15:0] ctl_word_i,
  input  logic        sts_rd_i,
  input  logic        dat_wr_i,
  input  logic [15:0] wr_data_i,
  input  logic        dat_rd_i,
  input  logic        sys_set_i,
  output logic [15:0] rd_data_o,
  output logic        irq_o
);

  ctl_t              dec;
  logic              wipe, restart;
  logic [RATE_W-1:0] rate_q;
  logic              ien_q, ien_d, cclr_q, wsel_q;
  logic              tick_w, match_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              lim_f, lost_f, sys_f, lim_n, lost_n, sys_n;
  logic [15:0]       status_w;
  logic [15:0]       rd_q;
  logic              irq_q;

  assign dec     = decode_ctl(ctl_word_i);
  assign wipe    = rst | io_rst_i | (ctl_wr_i & dec.mreset);
  assign restart = ctl_wr_i & dec.load_rate;

  always_comb begin
    if (wipe)          ien_d = 1'b0;
    else if (ctl_wr_i) ien_d = dec.irq_en;
    else               ien_d = ien_q;
  end

  always_ff @(posedge clk) begin
    ien_q <= ien_d;
    if (wipe) begin
      rate_q <= '0;
      cclr_q <= 1'b0;
      wsel_q <= 1'b0;
    end else if (ctl_wr_i) begin
      cclr_q <= dec.cnt_clr_en;
      wsel_q <= dec.wr_to_cnt;
      if (dec.load_rate) rate_q <= dec.rate;
    end
  end

  dit_divider #(.BASE_DIV(BASE_DIV), .STEP_DIV(STEP_DIV)) u_div (
    .clk     (clk),
    .rst     (wipe),
    .restart (restart),
    .rate_i  (rate_q),
    .tick_o  (tick_w)
  );

  dit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (wipe),
    .tick_i       (tick_w),
    .wr_en_i      (dat_wr_i),
    .wr_to_cnt_i  (wsel_q),
    .cnt_clr_en_i (cclr_q),
    .wr_val_i     (wr_data_i[CNT_W-1:0]),
    .cnt_o        (cnt_w),
    .match_o      (match_w)
  );

  dit_flags u_flg (
    .clk        (clk),
    .rst        (wipe),
    .ctl_wr_i   (ctl_wr_i),
    .clr_all_i  (dec.clr_all),
    .clr_code_i (dec.clr_code),
    .match_i    (match_w),
    .sys_set_i  (sys_set_i),
    .lim_q      (lim_f),
    .lost_q     (lost_f),
    .sys_q      (sys_f),
    .lim_d      (lim_n),
    .lost_d     (lost_n),
    .sys_d      (sys_n)
  );

  assign status_w = pack_status(rate_q, lim_f, lost_f, sys_f, wsel_q, cclr_q);

  always_ff @(posedge clk) begin
    if (rst || io_rst_i) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (sts_rd_i)      rd_q <= status_w;
      else if (dat_rd_i) rd_q <= 16'(cnt_w);
      irq_q <= sys_n | (ien_d & (lim_n | lost_n));
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             io_rst,
  input logic             ctl_wr,
  input logic [15:0]      ctl_word,
  input logic             sts_rd,
  input logic             dat_wr,
  input logic [15:0]      rd_data,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       rate,
  input logic             tick,
  input logic             lim_f,
  input logic             lost_f,
  input logic             sys_f
);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  p_tick_rate_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (rate != 3'd0));

  p_rate0_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rate == 3'd0 && !dat_wr && !ctl_wr && !io_rst) |-> $stable(cnt));

  p_lost_after_lim_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_f) |-> $past(lim_f));

  p_status_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    $past(sts_rd && !io_rst) |-> (rd_data[15:14] == 2'b01));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sys_f || lim_f || lost_f));

  p_mreset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_wr && !ctl_word[12] && ctl_word[15]) |->
      (cnt == '0 && rate == 3'd0 && !lim_f && !lost_f && !sys_f));

endmodule

bind dec_itimer dit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_rst   (io_rst_i),
  .ctl_wr   (ctl_wr_i),
  .ctl_word (ctl_word_i),
  .sts_rd   (sts_rd_i),
  .dat_wr   (dat_wr_i),
  .rd_data  (rd_data_o),
  .irq      (irq_o),
  .cnt      (cnt_w),
  .rate     (rate_q),
  .tick     (tick_w),
  .lim_f    (lim_f),
  .lost_f   (lost_f),
  .sys_f    (sys_f)
);

// File: tb/dec_itimer_bench.sv
module dec_itimer_bench;
  localparam int BASE = 3;
  localparam int STEP = 10;
  localparam int CW   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, io_rst = 1'b0, ctl_wr = 1'b0, sts_rd = 1'b0;
  logic        dat_wr = 1'b0, dat_rd = 1'b0, sys_set = 1'b0;
  logic [15:0] ctl_word = '0, wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  dec_itimer #(.BASE_DIV(BASE), .STEP_DIV(STEP), .CNT_W(CW)) u_dec_itimer (
    .clk(clk), .rst(rst), .io_rst_i(io_rst), .ctl_wr_i(ctl_wr), .ctl_word_i(ctl_word),
    .sts_rd_i(sts_rd), .dat_wr_i(dat_wr), .wr_data_i(wr_data), .dat_rd_i(dat_rd),
    .sys_set_i(sys_set), .rd_data_o(rd_data), .irq_o(irq));

  int total = 0, bad = 0;

  // Reference model state
  logic [CW-1:0] m_cnt = '0, m_lim = '0;
  logic [2:0]    m_rate = '0;
  logic          m_lf = 0, m_lost = 0, m_sys = 0, m_ien = 0, m_crst = 0, m_wsel = 0;
  longint        m_div = 0;
  logic [15:0]   m_rd = '0;
  string         rd_tag = "R9 reset read data";

  function automatic longint period(input logic [2:0] r);
    longint p = BASE;
    for (int i = 1; i < int'(r); i++) p = p * STEP;
    return p;
  endfunction

  function automatic logic [15:0] stat_word();
    return {1'b0, 1'b1, m_rate, 5'b0, m_lf, m_lost, 1'b0, m_sys, m_wsel, m_crst};
  endfunction

  function automatic logic m_irq();
    return m_sys | (m_ien & (m_lf | m_lost));
  endfunction

  task automatic wipe_model();
    m_cnt = '0; m_lim = '0; m_rate = '0; m_lf = 0; m_lost = 0; m_sys = 0;
    m_ien = 0; m_crst = 0; m_wsel = 0; m_div = 0;
  endtask

  task automatic model_step();
    logic ld, mr, tk;
    logic [CW-1:0] nc;
    if (rst || io_rst) begin
      wipe_model();
      m_rd = '0;
      rd_tag = "R9 reset read data";
      return;
    end
    ld = ctl_wr && ctl_word[12];
    mr = ctl_wr && !ctl_word[12] && ctl_word[15];
    tk = (m_rate != 0) && ((m_div % period(m_rate)) == period(m_rate) - 1) && !ld;
    if (sts_rd) begin m_rd = stat_word(); rd_tag = "R8 status word"; end
    else if (dat_rd) begin m_rd = 16'(m_cnt); rd_tag = "R3 count read"; end
    if (mr) begin wipe_model(); return; end
    m_div = ld ? 0 : m_div + 1;
    if (ctl_wr) begin
      if (ctl_word[5]) begin m_lf = 0; m_lost = 0; m_sys = 0; end
      else case (ctl_word[10:8])
        3'd1: m_lf = 0;
        3'd2: m_lost = 0;
        3'd3: m_sys = 0;
        default: ;
      endcase
    end
    nc = m_cnt;
    if (tk) begin
      nc = m_cnt + 1'b1;
      if (nc == m_lim) begin
        if (m_lf) m_lost = 1; else m_lf = 1;
        if (m_crst) nc = '0;
      end
    end
    if (dat_wr) begin
      if (m_wsel) nc = '0; else m_lim = wr_data[CW-1:0];
    end
    m_cnt = nc;
    if (sys_set) m_sys = 1;
    if (ctl_wr) begin
      m_crst = ctl_word[7]; m_wsel = ctl_word[6]; m_ien = ctl_word[0];
      if (ld) m_rate = ctl_word[15:13];
    end
  endtask

  always @(posedge clk) model_step();

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison of both outputs with the model
  always @(negedge clk) if (!rst) begin
    chk("R10 irq level", {15'b0, irq}, {15'b0, m_irq()});
    chk(rd_tag, rd_data, m_rd);
  end

  task automatic clr();
    ctl_wr = 0; sts_rd = 0; dat_wr = 0; dat_rd = 0; sys_set = 0; io_rst = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic ctl(input logic [15:0] w);
    @(negedge clk); clr(); ctl_wr = 1; ctl_word = w;
  endtask
  task automatic wr(input logic [15:0] d);
    @(negedge clk); clr(); dat_wr = 1; wr_data = d;
  endtask
  task automatic rd_cnt();
    @(negedge clk); clr(); dat_rd = 1;
  endtask
  task automatic rd_sts();
    @(negedge clk); clr(); sts_rd = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset rd_data", rd_data, 16'h0000);
    chk("R10 reset irq", {15'b0, irq}, 16'h0);
    rd_sts(); idle(1);
    chk("R8 idle status", rd_data, 16'h4000);

    // R1: rate load and non-load control write
    ctl(16'h7000); rd_sts(); idle(1);
    chk("R1 rate loaded", {13'b0, rd_data[13:11]}, 16'd3);
    ctl(16'h6000); rd_sts(); idle(1);
    chk("R1 rate kept without load bit", {13'b0, rd_data[13:11]}, 16'd3);

    // R2: exact tick period per rate, first tick a full period after load
    for (int r = 1; r <= 3; r++) begin
      for (int h = 0; h < 2; h++) begin
        ctl(16'h8000);
        ctl({r[2:0], 1'b1, 5'b0, 1'b1, 6'b0});
        wr(16'hFFFF);
        idle(int'(3 * period(r[2:0])) - h - 1);
        rd_cnt(); idle(1);
        chk($sformatf("R2 rate %0d period count", r), rd_data, 16'(3 - h));
      end
    end
    ctl(16'h1040); wr(16'h0); idle(50); rd_cnt(); idle(1);
    chk("R2 rate 0 holds count", rd_data, 16'h0);

    // R4 and R5: match, wrap, lost tick; R7 clears
    ctl(16'h8000); ctl(16'h3041); wr(16'h0); ctl(16'h3001); wr(16'h0005);
    idle(30); rd_sts(); idle(1);
    chk("R4 limit-match then no lost", {14'b0, rd_data[5:4]}, 16'b10);
    chk("R10 irq from match", {15'b0, irq}, 16'h1);
    idle(256 * 3); rd_sts(); idle(1);
    chk("R5 lost tick after wrap", {14'b0, rd_data[5:4]}, 16'b11);
    ctl(16'h0201); rd_sts(); idle(1);
    chk("R7 clear lost only", {14'b0, rd_data[5:4]}, 16'b10);
    ctl(16'h0401); rd_sts(); idle(1);
    chk("R7 code 4 no effect", {14'b0, rd_data[5:4]}, 16'b10);
    ctl(16'h0321); rd_sts(); idle(1);
    chk("R7 clear all wins", {13'b0, rd_data[5:4], rd_data[2]}, 16'b0);
    chk("R10 irq low after clear", {15'b0, irq}, 16'h0);

    // R4: limit below count only matches after wrap
    ctl(16'h8000); ctl(16'h3040); wr(16'h0); idle(30);
    ctl(16'h3000); wr(16'h0003); idle(100); rd_sts(); idle(1);
    chk("R4 limit below count no match", {15'b0, rd_data[5]}, 16'h0);

    // R4: count clear on match
    ctl(16'h8000); ctl(16'h30C0); wr(16'h0); ctl(16'h3080); wr(16'h0004);
    idle(60); rd_cnt(); idle(1);
    chk("R4 count cleared on match", {15'b0, rd_data > 16'd3}, 16'h0);

    // R10, R11: system flag and same-cycle set versus clear
    ctl(16'h8000);
    @(negedge clk); clr(); sys_set = 1; idle(1);
    chk("R10 system flag drives irq", {15'b0, irq}, 16'h1);
    ctl(16'h0300); idle(1);
    chk("R10 system clear drops irq", {15'b0, irq}, 16'h0);
    @(negedge clk); clr(); ctl_wr = 1; ctl_word = 16'h0020; sys_set = 1;
    rd_sts(); idle(1);
    chk("R11 set beats clear", {15'b0, rd_data[2]}, 16'h1);

    // R9: external reset
    ctl(16'h30C1);
    @(negedge clk); clr(); io_rst = 1;
    rd_sts(); idle(1);
    chk("R9 io reset status", rd_data, 16'h4000);

    // Random mix (R6, R11 and all others through the model)
    for (int i = 0; i < 6000; i++) begin
      case ($urandom % 10)
        0, 1, 2: idle(1);
        3: begin
          w = 16'($urandom);
          w[15:13] = 3'($urandom % 3);
          w[12] = ($urandom % 4 == 0);
          if (!w[12]) w[15] = 1'b0;
          ctl(w);
        end
        4: wr(16'($urandom % 24));
        5: rd_cnt();
        6: rd_sts();
        7: begin @(negedge clk); clr(); sys_set = ($urandom % 3 == 0); end
        8: ctl({5'b0, 3'($urandom % 8), 2'b0, 1'($urandom % 2), 4'b0, 1'b1});
        default: begin
          if ($urandom % 20 == 0) ctl(16'h8000);
          else if ($urandom % 20 == 0) begin @(negedge clk); clr(); io_rst = 1; end
          else idle(1);
        end
      endcase
    end
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule